// File: doc/BRIEF.md
# Word-Machine Processor Core

This block is a multi-cycle processor for a small virtual machine built on 16-bit words. A word in an instruction stream is read in one of two ways: as a literal value below 32768, or as a reference to one of eight general registers (32768 to 32775). An instruction is an opcode word followed by zero to three operand words. The core reads one word per fetch step, resolves each operand into a value as it arrives, and then executes the instruction and moves the program counter. All arithmetic wraps at 2^15.

Program and data share one internal synchronous word RAM. A testbench or boot agent fills it through a load port while the core is idle, then pulses `start`. Subroutine return addresses and pushed values go to a hardware LIFO of fixed depth. Characters leave through a one-cycle valid/data port. Characters come in through a ready/valid handshake, and the core waits in place until a byte arrives. A halt instruction stops the core cleanly. Any illegal condition stops it with a fault code. Both stop conditions hold until reset.

Top module: `wordvm_core`

## Requirements
- R1: After reset the core is idle. `halted`, `faulted`, `out_valid` and `in_ready` are low and `fault_code` is 0. The core executes nothing until `start` is pulsed, and the load port writes RAM word `ld_addr` only while the core is idle. Execution begins at address 0.
- R2: An operand word in 0..32767 is its own value. A word in 32768..32775 yields the contents of register (word − 32768). Any larger word stops the core with fault code 2.
- R3: An opcode word must be a literal in 0..21, with 0 halt, 1 set, 2 push, 3 pop, 4 eq, 5 gt, 6 jmp, 7 jt, 8 jf, 9 add, 10 mult, 11 mod, 12 and, 13 or, 14 not, 15 rmem, 16 wmem, 17 call, 18 ret, 19 out, 20 in, 21 nop. Any other opcode word stops the core with fault code 1.
- R4: add and mult write (b op c) mod 32768. mod writes b mod c. and/or write the bitwise result. not writes the bitwise inverse of b kept to 15 bits. The destination is the first operand.
- R5: eq writes 1 if b equals c, else 0. gt writes 1 if b is greater than c as unsigned numbers, else 0.
- R6: jmp always loads its operand into the program counter. jt jumps to b when a is nonzero. jf jumps to b when a is zero. Otherwise execution falls through to the next instruction.
- R7: push and pop form a LIFO. call pushes the address of the word after its operand and then jumps. ret pops that address into the program counter.
- R8: rmem a,b loads RAM[b] into register a. wmem a,b stores b to RAM[a]. Every RAM address is taken from the low ADDR_W bits of the value, so with ADDR_W = 11, address 2348 aliases 300.
- R9: out pulses `out_valid` for exactly one cycle, with `out_char` equal to the low 8 bits of its operand.
- R10: in raises `in_ready` and holds it, without executing anything further, until `in_valid` is seen. The byte is then stored zero-extended into the destination register.
- R11: halt sets `halted` with `fault_code` 0. No instruction after it executes and no further output appears.
- R12: A write to a destination that is a literal faults with code 3. pop or ret on an empty stack faults with code 4. push or call with STACK_DEPTH entries already held faults with code 5. mod by zero faults with code 6 and writes no result.
- R13: `halted` and `faulted` are never high together. Once either is high it stays high, and `fault_code` holds, until reset. `start` has no effect while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 (idle only) |
| ld_en | input | 1 | Write strobe of the load port (idle only) |
| ld_addr | input | ADDR_W | RAM word address for loading |
| ld_data | input | 16 | Word to load |
| in_valid | input | 1 | Input character available |
| in_char | input | 8 | Input character |
| in_ready | output | 1 | Core is waiting for an input character |
| out_valid | output | 1 | One-cycle strobe for an output character |
| out_char | output | 8 | Output character |
| halted | output | 1 | Sticky: halt executed |
| faulted | output | 1 | Sticky: core stopped on a fault |
| fault_code | output | 3 | Cause of the fault, 0 when none |

## Verification
An operand that resolves to the wrong register or value changes the outcome of the next compare or arithmetic instruction. Each random program therefore follows every result with an equality test against a bench-computed value, so a corrupted datapath shows on `out_char` within two instructions. A program counter or stack pointer that goes astray shows up as missing or reordered output characters, or as a wrong stop flag or fault code. Fault detection that misfires leaves the core running into a halt where a fault was expected, or the reverse, and that difference is visible on the sticky flags.

// File: rtl/wvm_pkg.sv
package wvm_pkg;
    localparam int WORD_W   = 16;
    localparam int NUM_REGS = 8;
    localparam int VAL_W    = 15;

    typedef enum logic [4:0] {
        OP_HALT = 5'd0,  OP_SET  = 5'd1,  OP_PUSH = 5'd2,  OP_POP  = 5'd3,
        OP_EQ   = 5'd4,  OP_GT   = 5'd5,  OP_JMP  = 5'd6,  OP_JT   = 5'd7,
        OP_JF   = 5'd8,  OP_ADD  = 5'd9,  OP_MULT = 5'd10, OP_MOD  = 5'd11,
        OP_AND  = 5'd12, OP_OR   = 5'd13, OP_NOT  = 5'd14, OP_RMEM = 5'd15,
        OP_WMEM = 5'd16, OP_CALL = 5'd17, OP_RET  = 5'd18, OP_OUT  = 5'd19,
        OP_IN   = 5'd20, OP_NOP  = 5'd21
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_ARG, S_EXEC, S_MEMRD, S_INWAIT, S_STOP
    } state_e;

    localparam logic [2:0] FC_NONE   = 3'd0;
    localparam logic [2:0] FC_OPCODE = 3'd1;
    localparam logic [2:0] FC_WORD   = 3'd2;
    localparam logic [2:0] FC_DEST   = 3'd3;
    localparam logic [2:0] FC_EMPTY  = 3'd4;
    localparam logic [2:0] FC_FULL   = 3'd5;
    localparam logic [2:0] FC_DIVZ   = 3'd6;

    function automatic logic [1:0] arg_count(op_e op);
        case (op)
            OP_HALT, OP_RET, OP_NOP:                             return 2'd0;
            OP_PUSH, OP_POP, OP_JMP, OP_CALL, OP_OUT, OP_IN:     return 2'd1;
            OP_SET, OP_JT, OP_JF, OP_NOT, OP_RMEM, OP_WMEM:      return 2'd2;
            default:                                             return 2'd3;
        endcase
    endfunction

    function automatic logic writes_dest(op_e op);
        case (op)
            OP_SET, OP_POP, OP_EQ, OP_GT, OP_ADD, OP_MULT, OP_MOD,
            OP_AND, OP_OR, OP_NOT, OP_RMEM, OP_IN:               return 1'b1;
            default:                                             return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/wvm_opdec.sv
module wvm_opdec
    import wvm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic              is_reg,
    output logic [2:0]        sel,
    output logic              bad
);
    assign is_reg = word[WORD_W-1] && (word[WORD_W-2:3] == '0);
    assign sel    = word[2:0];
    assign bad    = word[WORD_W-1] && !is_reg;
endmodule

// File: rtl/wvm_alu.sv
module wvm_alu
    import wvm_pkg::*;
(
    input  op_e               op,
    input  logic [WORD_W-1:0] b,
    input  logic [WORD_W-1:0] c,
    output logic [WORD_W-1:0] res,
    output logic              div0
);
    logic [VAL_W-1:0] sum15;
    logic [VAL_W-1:0] prod15;

    assign sum15  = VAL_W'(b + c);
    assign prod15 = VAL_W'(b * c);
    assign div0   = (op == OP_MOD) && (c == '0);

    always_comb begin
        res = '0;
        case (op)
            OP_EQ:   res = {{(WORD_W-1){1'b0}}, b == c};
            OP_GT:   res = {{(WORD_W-1){1'b0}}, b > c};
            OP_ADD:  res = {1'b0, sum15};
            OP_MULT: res = {1'b0, prod15};
            OP_MOD:  res = (c == '0) ? '0 : (b % c);
            OP_AND:  res = b & c;
            OP_OR:   res = b | c;
            OP_NOT:  res = {1'b0, ~b[VAL_W-1:0]};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/wvm_stack.sv
module wvm_stack #(
    parameter int DEPTH = 16,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] top_idx;
    logic [IW-1:0] wr_idx;

    assign top_idx = IW'(cnt_q - 1'b1);
    assign wr_idx  = IW'(cnt_q);
    assign top     = mem[top_idx];
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            mem[wr_idx] <= din;
            cnt_q       <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/wvm_ram.sv
module wvm_ram #(
    parameter int ADDR_W = 11,
    parameter int W      = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/wordvm_core.sv
module wordvm_core
    import wvm_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int STACK_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [15:0]       ld_data,
    input  logic              in_valid,
    input  logic [7:0]        in_char,
    output logic              in_ready,
    output logic              out_valid,
    output logic [7:0]        out_char,
    output logic              halted,
    output logic              faulted,
    output logic [2:0]        fault_code
);
    typedef struct packed {
        state_e                          st;
        logic [ADDR_W-1:0]               pc;
        op_e                             opc;
        logic [1:0]                      nargs;
        logic [1:0]                      idx;
        logic                            dst_reg;
        logic [2:0]                      dst_sel;
        logic [2:0][WORD_W-1:0]          val;
        logic [NUM_REGS-1:0][WORD_W-1:0] regs;
        logic                            out_v;
        logic [7:0]                      out_c;
        logic                            halted;
        logic                            faulted;
        logic [2:0]                      fcode;
    } core_t;

    core_t q, n;

    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [WORD_W-1:0] ram_wdata;
    logic [WORD_W-1:0] ram_rdata;
    logic              core_we;
    logic [ADDR_W-1:0] core_addr;
    logic [WORD_W-1:0] core_wdata;
    logic              loading;

    logic              stk_push, stk_pop, stk_empty, stk_full;
    logic [WORD_W-1:0] stk_din, stk_top;
    logic [WORD_W-1:0] alu_res;
    logic              alu_div0;
    logic              od_reg, od_bad;
    logic [2:0]        od_sel;
    logic [WORD_W-1:0] arg_a, arg_b;

    assign loading   = (q.st == S_IDLE);
    assign ram_we    = loading ? ld_en   : core_we;
    assign ram_addr  = loading ? ld_addr : core_addr;
    assign ram_wdata = loading ? ld_data : core_wdata;
    assign arg_a     = q.val[0];
    assign arg_b     = q.val[1];

    wvm_ram #(.ADDR_W(ADDR_W), .W(WORD_W)) ram_i (
        .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
    );

    wvm_stack #(.DEPTH(STACK_DEPTH), .W(WORD_W)) stack_i (
        .clk(clk), .rst_n(rst_n), .push(stk_push), .pop(stk_pop), .din(stk_din),
        .top(stk_top), .empty(stk_empty), .full(stk_full)
    );

    wvm_alu alu_i (
        .op(q.opc), .b(q.val[1]), .c(q.val[2]), .res(alu_res), .div0(alu_div0)
    );

    wvm_opdec opdec_i (
        .word(ram_rdata), .is_reg(od_reg), .sel(od_sel), .bad(od_bad)
    );

    function automatic core_t raise(core_t s, logic [2:0] code);
        s.faulted = 1'b1;
        s.fcode   = code;
        s.st      = S_STOP;
        return s;
    endfunction

    always_comb begin
        n          = q;
        n.out_v    = 1'b0;
        core_we    = 1'b0;
        core_addr  = q.pc;
        core_wdata = '0;
        stk_push   = 1'b0;
        stk_pop    = 1'b0;
        stk_din    = '0;
        case (q.st)
            S_IDLE: begin
                if (start) n.st = S_FETCH;
            end
            S_FETCH: begin
                n.pc = q.pc + 1'b1;
                n.st = S_DECODE;
            end
            S_DECODE: begin
                if (ram_rdata[WORD_W-1] || (ram_rdata[VAL_W-1:0] > VAL_W'(21))) begin
                    n = raise(n, FC_OPCODE);
                end else begin
                    n.opc   = op_e'(ram_rdata[4:0]);
                    n.nargs = arg_count(op_e'(ram_rdata[4:0]));
                    n.idx   = 2'd0;
                    if (n.nargs == 2'd0) begin
                        n.st = S_EXEC;
                    end else begin
                        n.pc = q.pc + 1'b1;
                        n.st = S_ARG;
                    end
                end
            end
            S_ARG: begin
                if (od_bad) begin
                    n = raise(n, FC_WORD);
                end else begin
                    n.val[q.idx] = od_reg ? q.regs[od_sel] : ram_rdata;
                    if (q.idx == 2'd0) begin
                        n.dst_reg = od_reg;
                        n.dst_sel = od_sel;
                    end
                    if (q.idx + 2'd1 == q.nargs) begin
                        n.st = S_EXEC;
                    end else begin
                        n.idx = q.idx + 2'd1;
                        n.pc  = q.pc + 1'b1;
                    end
                end
            end
            S_EXEC: begin
                if (writes_dest(q.opc) && !q.dst_reg) begin
                    n = raise(n, FC_DEST);
                end else begin
                    n.st = S_FETCH;
                    case (q.opc)
                        OP_HALT: begin
                            n.halted = 1'b1;
                            n.st     = S_STOP;
                        end
                        OP_SET: n.regs[q.dst_sel] = arg_b;
                        OP_PUSH: begin
                            if (stk_full) begin
                                n = raise(n, FC_FULL);
                            end else begin
                                stk_push = 1'b1;
                                stk_din  = arg_a;
                            end
                        end
                        OP_POP: begin
                            if (stk_empty) begin
                                n = raise(n, FC_EMPTY);
                            end else begin
                                stk_pop = 1'b1;
                                n.regs[q.dst_sel] = stk_top;
                            end
                        end
                        OP_EQ, OP_GT, OP_ADD, OP_MULT, OP_AND, OP_OR, OP_NOT:
                            n.regs[q.dst_sel] = alu_res;
                        OP_MOD: begin
                            if (alu_div0) n = raise(n, FC_DIVZ);
                            else          n.regs[q.dst_sel] = alu_res;
                        end
                        OP_JMP: n.pc = arg_a[ADDR_W-1:0];
                        OP_JT:  if (arg_a != '0) n.pc = arg_b[ADDR_W-1:0];
                        OP_JF:  if (arg_a == '0) n.pc = arg_b[ADDR_W-1:0];
                        OP_RMEM: begin
                            core_addr = arg_b[ADDR_W-1:0];
                            n.st      = S_MEMRD;
                        end
                        OP_WMEM: begin
                            core_we    = 1'b1;
                            core_addr  = arg_a[ADDR_W-1:0];
                            core_wdata = arg_b;
                        end
                        OP_CALL: begin
                            if (stk_full) begin
                                n = raise(n, FC_FULL);
                            end else begin
                                stk_push = 1'b1;
                                stk_din  = WORD_W'(q.pc);
                                n.pc     = arg_a[ADDR_W-1:0];
                            end
                        end
                        OP_RET: begin
                            if (stk_empty) begin
                                n = raise(n, FC_EMPTY);
                            end else begin
                                stk_pop = 1'b1;
                                n.pc    = stk_top[ADDR_W-1:0];
                            end
                        end
                        OP_OUT: begin
                            n.out_v = 1'b1;
                            n.out_c = arg_a[7:0];
                        end
                        OP_IN:  n.st = S_INWAIT;
                        default: ;
                    endcase
                end
            end
            S_MEMRD: begin
                n.regs[q.dst_sel] = ram_rdata;
                n.st              = S_FETCH;
            end
            S_INWAIT: begin
                if (in_valid) begin
                    n.regs[q.dst_sel] = {8'h00, in_char};
                    n.st              = S_FETCH;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign in_ready   = (q.st == S_INWAIT);
    assign out_valid  = q.out_v;
    assign out_char   = q.out_c;
    assign halted     = q.halted;
    assign faulted    = q.faulted;
    assign fault_code = q.fcode;
endmodule

// File: rtl/wvm_chk.sv
module wvm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halted,
    input logic       faulted,
    input logic [2:0] fault_code,
    input logic       out_valid,
    input logic       in_ready,
    input logic       in_valid
);
    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    // R13
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        faulted |=> faulted);
    // R13
    stop_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !faulted);
    // R11
    halt_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (fault_code == 3'd0));
    // R12
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        faulted |-> (fault_code != 3'd0));
    // R13
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted || faulted) |=> $stable(fault_code));
    // R9
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R11
    quiet_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted || faulted) |-> !out_valid);
    // R10
    in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> in_ready);
endmodule

bind wordvm_core wvm_chk chk_i (
    .clk(clk), .rst_n(rst_n), .halted(halted), .faulted(faulted),
    .fault_code(fault_code), .out_valid(out_valid), .in_ready(in_ready),
    .in_valid(in_valid)
);

// File: tb/wordvm_core_tb_top.sv
`timescale 1ns/1ps
module wordvm_core_tb_top;
    localparam int AW = 11;
    localparam int SD = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, start = 1'b0, ld_en = 1'b0, in_valid = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [15:0]   ld_data = '0;
    logic [7:0]    in_char = '0;
    logic          in_ready, out_valid, halted, faulted;
    logic [7:0]    out_char;
    logic [2:0]    fault_code;

    always #4 clk = ~clk;

    wordvm_core #(.ADDR_W(AW), .STACK_DEPTH(SD)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .in_valid(in_valid), .in_char(in_char), .in_ready(in_ready),
        .out_valid(out_valid), .out_char(out_char), .halted(halted), .faulted(faulted),
        .fault_code(fault_code)
    );

    int checks = 0, errors = 0;
    logic [15:0] prog [0:63];
    int plen = 0;
    int obuf [0:1023];
    int ocount = 0, obase = 0, rdy_cycles = 0;

    always @(negedge clk) begin
        if (out_valid && ocount < 1024) begin
            obuf[ocount] = int'(out_char);
            ocount++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic newp(); plen = 0; endtask
    task automatic e(input int w); prog[plen] = 16'(w); plen++; endtask

    function automatic int nout(); return ocount - obase; endfunction
    function automatic int outv(input int i); return obuf[obase + i]; endfunction

    function automatic int model(input int op, input int b, input int c);
        case (op)
            4:  return (b == c) ? 1 : 0;
            5:  return (b > c) ? 1 : 0;
            9:  return (b + c) % 32768;
            10: return (b * c) % 32768;
            11: return b % c;
            12: return b & c;
            13: return b | c;
            default: return (~b) & 32767;
        endcase
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; ld_en = 1'b0; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input string tag, input int in_delay, input logic [7:0] ib);
        bit done;
        do_reset();
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = AW'(i); ld_data = prog[i];
        end
        @(negedge clk);
        ld_en = 1'b0; obase = ocount; rdy_cycles = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        done = 1'b0;
        for (int k = 0; k < 4000 && !done; k++) begin
            @(negedge clk);
            if (halted || faulted) done = 1'b1;
            else if (in_ready) begin
                rdy_cycles++;
                if (rdy_cycles >= in_delay) begin in_valid = 1'b1; in_char = ib; end
            end else in_valid = 1'b0;
        end
        in_valid = 1'b0;
        chk(done, {tag, " stop reached"}, int'(done), 1);
    endtask

    task automatic expect_stop(input string tag, input bit h, input bit f, input int code);
        chk(halted == h && faulted == f && int'(fault_code) == code, tag,
            int'({halted, faulted, fault_code}), int'({h, f, 3'(code)}));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R13 watchdog actual %0d expected %0d", 150000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state and idle without start
        do_reset();
        @(negedge clk);
        chk(!halted && !faulted && !out_valid && !in_ready && fault_code == 0,
            "R1 reset state", int'({halted, faulted, out_valid, in_ready}), 0);
        repeat (10) @(negedge clk);
        chk(!halted && !faulted && ocount == 0, "R1 idle without start", ocount, 0);

        // R11 / R13: halt stops output; later start ignored
        newp(); e(19); e(72); e(0); e(19); e(73);
        run("R11", 1, 8'h00);
        expect_stop("R11 halt flags", 1, 0, 0);
        chk(nout() == 1 && outv(0) == 72, "R11 output before halt", nout(), 1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        expect_stop("R13 start ignored after halt", 1, 0, 0);
        chk(nout() == 1, "R13 no output after restart attempt", nout(), 1);

        // R6: jumps
        newp();
        e(7); e(1); e(6); e(19); e(120); e(0);
        e(7); e(0); e(3); e(8); e(5); e(3); e(8); e(0); e(17);
        e(19); e(120); e(19); e(74); e(6); e(22); e(0); e(19); e(75); e(0);
        run("R6", 1, 8'h00);
        expect_stop("R6 halted", 1, 0, 0);
        chk(nout() == 2 && outv(0) == 74 && outv(1) == 75, "R6 jump path", nout() > 0 ? outv(0) : -1, 74);

        // R7: push/pop order
        newp(); e(2); e(10); e(2); e(20); e(3); e(32768); e(3); e(32769);
        e(19); e(32768); e(19); e(32769); e(0);
        run("R7", 1, 8'h00);
        chk(nout() == 2 && outv(0) == 20 && outv(1) == 10, "R7 LIFO order", nout() > 0 ? outv(0) : -1, 20);

        // R7: call / ret
        newp(); e(17); e(5); e(19); e(66); e(0); e(19); e(65); e(18);
        run("R7", 1, 8'h00);
        expect_stop("R7 call/ret halted", 1, 0, 0);
        chk(nout() == 2 && outv(0) == 65 && outv(1) == 66, "R7 call return address", nout() > 1 ? outv(1) : -1, 66);

        // R8: rmem / wmem with register address and aliasing
        newp();
        e(16); e(200); e(4321); e(15); e(32771); e(200); e(4); e(32772); e(32771); e(4321);
        e(19); e(32772); e(1); e(32773); e(201); e(16); e(32773); e(77);
        e(15); e(32774); e(201); e(19); e(32774);
        e(16); e(300); e(9); e(16); e(2348); e(55); e(15); e(32775); e(300); e(19); e(32775); e(0);
        run("R8", 1, 8'h00);
        chk(nout() == 3 && outv(0) == 1, "R8 word round trip", nout() > 0 ? outv(0) : -1, 1);
        chk(nout() == 3 && outv(1) == 77, "R8 register address", nout() > 1 ? outv(1) : -1, 77);
        chk(nout() == 3 && outv(2) == 55, "R8 address aliasing", nout() > 2 ? outv(2) : -1, 55);

        // R10: input stall and handshake
        newp(); e(20); e(32770); e(19); e(32770); e(9); e(32770); e(32770); e(1); e(19); e(32770); e(0);
        run("R10", 8, 8'd65);
        chk(rdy_cycles >= 8, "R10 ready held while waiting", rdy_cycles, 8);
        chk(nout() == 2 && outv(0) == 65 && outv(1) == 66, "R10 input value", nout() > 1 ? outv(1) : -1, 66);

        // R3: bad opcodes
        newp(); e(22);
        run("R3", 1, 8'h00);
        expect_stop("R3 opcode 22", 0, 1, 1);
        newp(); e(32768);
        run("R3", 1, 8'h00);
        expect_stop("R3 register as opcode", 0, 1, 1);

        // R2: invalid operand word
        newp(); e(1); e(32776); e(5);
        run("R2", 1, 8'h00);
        expect_stop("R2 invalid operand word", 0, 1, 2);

        // R12: destination literal, empty stack, full stack, mod zero
        newp(); e(1); e(7); e(5);
        run("R12", 1, 8'h00);
        expect_stop("R12 literal destination", 0, 1, 3);
        newp(); e(3); e(32768);
        run("R12", 1, 8'h00);
        expect_stop("R12 pop empty", 0, 1, 4);
        newp(); e(18);
        run("R12", 1, 8'h00);
        expect_stop("R12 ret empty", 0, 1, 4);
        newp(); e(2); e(5); e(6); e(0);
        run("R12", 1, 8'h00);
        expect_stop("R12 stack overflow", 0, 1, 5);
        newp(); e(19); e(77); e(11); e(32768); e(5); e(0); e(19); e(78); e(0);
        run("R12", 1, 8'h00);
        expect_stop("R12 mod by zero", 0, 1, 6);
        chk(nout() == 1 && outv(0) == 77, "R12 no progress after fault", nout(), 1);

        // R2 R4 R5 R9: random and corner arithmetic through register operands
        for (int t = 0; t < 48; t++) begin
            int ops [8] = '{9, 10, 11, 12, 13, 14, 4, 5};
            int op, b, c, x;
            op = ops[$urandom % 8];
            b  = int'($urandom % 32768);
            c  = int'($urandom % 32768);
            if (t == 0) begin op = 9;  b = 32767; c = 1; end
            if (t == 1) begin op = 10; b = 32767; c = 32767; end
            if (t == 2) begin op = 14; b = 0; end
            if (t == 3) begin op = 5;  c = b; end
            if (t == 4) begin op = 4;  c = b; end
            if (t == 5) begin op = 11; b = 5; c = 32767; end
            if (op == 11 && c == 0) c = 1;
            x = model(op, b, c);
            newp(); e(1); e(32769); e(b);
            if (op == 14) begin e(14); e(32768); e(32769); end
            else begin e(op); e(32768); e(32769); e(c); end
            e(19); e(32768); e(4); e(32770); e(32768); e(x); e(19); e(32770); e(0);
            run("R4", 1, 8'h00);
            if (op == 4 || op == 5)
                chk(nout() == 2 && outv(0) == (x & 255) && outv(1) == 1, "R5 compare result",
                    nout() > 0 ? outv(0) : -1, x & 255);
            else
                chk(nout() == 2 && outv(0) == (x & 255) && outv(1) == 1, "R4 R2 R9 arithmetic result",
                    nout() > 0 ? outv(0) : -1, x & 255);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule